// File: doc/BRIEF.md
# Comparison-Free One-Hot Sorter

This block puts a batch of unsigned elements in descending order without ever comparing one element against another. Each element that arrives is decoded into a one-hot word and written as its own row of a square bit matrix. The same element also enters a shift buffer in binary form. Once the matrix is full, the block reads it one column at a time, starting at the highest column. The set bits of a column gate their matching buffer entries onto the output. So the position of a bit in the transposed matrix decides the order, not a comparator network.

Software or an upstream engine sends a start pulse and then delivers exactly 2^VAL_W elements over a valid/ready input. The load phase then closes by itself and the read phase begins. Each column that holds at least one element produces one output beat. The beat carries the value and the number of elements equal to it, so repeated values arrive as a single beat. A one-cycle done pulse follows the last column. Loading takes N accepted cycles and reading takes N cycles, so a batch with no bubbles sorts in 2N cycles plus a short drain.

Top module: `onehot_sorter`

## Requirements
- R1: After reset, in_ready, out_valid and done are all low. The cycle after a start pulse, in_ready is high, which shows the block is accepting elements.
- R2: An element is accepted on each rising edge where in_valid and in_ready are both high. After exactly N = 2^VAL_W accepted elements, in_ready goes low.
- R3: In the read phase, output beats appear in strictly descending out_value order. Each beat's out_value is an element value present in the batch. Its out_count equals the number of batch elements holding that value, a number from 1 to N. The counts of a batch sum to N.
- R4: A value that no element of the batch holds produces no beat, so out_valid is never high with out_count zero.
- R5: The read phase scans all N columns, one per cycle. The beat for value v becomes visible N − v clock edges after the edge that accepted the last element. done becomes visible N + 1 edges after that same edge.
- R6: While in_ready is low, in_valid and in_data have no effect. This holds during the read phase and while the block is idle. Outside a load phase, in_ready is never high while out_valid is high.
- R7: A start pulse restarts the block from any phase. It clears the matrix and the write position and cancels any read in progress. No element is accepted in the start cycle itself, even if in_valid is high then.
- R8: done is high for exactly one cycle per completed batch, and never in the same cycle as out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new batch; clears all stored state |
| in_valid | input | 1 | in_data carries an element |
| in_data | input | VAL_W | Unsigned element |
| in_ready | output | 1 | High while the load phase can accept an element |
| out_valid | output | 1 | out_value and out_count form a beat |
| out_value | output | VAL_W | Element value of the current column |
| out_count | output | VAL_W+1 | Number of elements equal to out_value |
| done | output | 1 | One-cycle pulse after the last column |

## Verification
Two situations can arise in the same cycle: a start pulse together with an offered element, and a start pulse arriving while the read phase is still emitting beats. The bench sets up both. It raises start with in_valid high, carrying a value the next batch never uses. It also restarts a batch a few cycles into its readout. The cases are judged at the ports. The following batch must produce exactly N acceptances, and its beat stream must match the bench model with no trace of the foreign value or of the aborted batch. Elements offered during the readout and while idle must leave the beat stream unchanged.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_READ  = 2'd2,
        PH_FLUSH = 2'd3
    } phase_e;

    typedef struct packed {
        logic wipe;     // clear matrix
        logic write;    // store one element
        logic scan;     // a column is presented this cycle
        logic finish;   // read phase just ended
    } sort_cmd_t;

    function automatic int unsigned depth_of(input int unsigned width);
        return 32'd1 << width;
    endfunction

endpackage

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import sorter_pkg::*;
#(
    parameter int unsigned VAL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    output logic             in_ready,
    output sort_cmd_t        cmd,
    output logic [VAL_W-1:0] wr_pos,
    output logic [VAL_W-1:0] col_idx
);
    localparam logic [VAL_W-1:0] LAST = {VAL_W{1'b1}};

    phase_e phase_q;

    assign in_ready = (phase_q == PH_LOAD) && !start;

    always_comb begin
        cmd.wipe   = start;
        cmd.write  = in_valid && in_ready;
        cmd.scan   = (phase_q == PH_READ) && !start;
        cmd.finish = (phase_q == PH_FLUSH) && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            wr_pos  <= '0;
            col_idx <= '0;
        end else if (start) begin
            phase_q <= PH_LOAD;
            wr_pos  <= '0;
            col_idx <= '0;
        end else begin
            unique case (phase_q)
                PH_LOAD: begin
                    if (in_valid) begin
                        wr_pos <= wr_pos + 1'b1;
                        if (wr_pos == LAST) begin
                            phase_q <= PH_READ;
                            col_idx <= LAST;
                        end
                    end
                end
                PH_READ: begin
                    col_idx <= col_idx - 1'b1;
                    if (col_idx == '0) phase_q <= PH_FLUSH;
                end
                PH_FLUSH: phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sort_hot_matrix.sv
module sort_hot_matrix #(
    parameter int unsigned VAL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wipe,
    input  logic                 write,
    input  logic [VAL_W-1:0]     wr_pos,
    input  logic [VAL_W-1:0]     wr_val,
    input  logic [VAL_W-1:0]     col_idx,
    output logic [(1<<VAL_W)-1:0] col_bits
);
    localparam int unsigned N = 1 << VAL_W;

    logic [N-1:0] rows [N];
    logic [N-1:0] hot;

    // one-hot decode: value v sets only bit v
    assign hot = N'(1) << wr_val;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            for (int r = 0; r < N; r++) rows[r] <= '0;
        end else if (write) begin
            rows[wr_pos] <= hot;
        end
    end

    // transposed read: one bit from every row
    for (genvar r = 0; r < N; r++) begin : g_col
        assign col_bits[r] = rows[r][col_idx];
    end
endmodule

// File: rtl/sort_shift_buf.sv
module sort_shift_buf #(
    parameter int unsigned VAL_W = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              shift,
    input  logic [VAL_W-1:0]                  din,
    output logic [(1<<VAL_W)-1:0][VAL_W-1:0]  elems
);
    localparam int unsigned N = 1 << VAL_W;

    // new element enters at the top and moves down, so after N shifts
    // entry i holds the i-th arrival
    always_ff @(posedge clk) begin
        if (rst) begin
            elems <= '0;
        end else if (shift) begin
            elems[N-1] <= din;
            for (int j = 0; j < N - 1; j++) elems[j] <= elems[j+1];
        end
    end
endmodule

// File: rtl/sort_col_gate.sv
module sort_col_gate #(
    parameter int unsigned VAL_W = 4
) (
    input  logic [(1<<VAL_W)-1:0]             col_bits,
    input  logic [(1<<VAL_W)-1:0][VAL_W-1:0]  elems,
    output logic [VAL_W-1:0]                  sel_value,
    output logic [VAL_W:0]                    sel_count
);
    localparam int unsigned N = 1 << VAL_W;

    always_comb begin
        sel_value = '0;
        sel_count = '0;
        for (int r = 0; r < N; r++) begin
            sel_value = sel_value | (elems[r] & {VAL_W{col_bits[r]}});
            sel_count = sel_count + (VAL_W+1)'(col_bits[r]);
        end
    end
endmodule

// File: rtl/onehot_sorter.sv
module onehot_sorter
    import sorter_pkg::*;
#(
    parameter int unsigned VAL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    input  logic [VAL_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_value,
    output logic [VAL_W:0]   out_count,
    output logic             done
);
    localparam int unsigned N = depth_of(VAL_W);

    sort_cmd_t                 cmd;
    logic [VAL_W-1:0]          wr_pos;
    logic [VAL_W-1:0]          col_idx;
    logic [N-1:0]              col_bits;
    logic [N-1:0][VAL_W-1:0]   elems;
    logic [VAL_W-1:0]          sel_value;
    logic [VAL_W:0]            sel_count;

    sort_ctrl #(.VAL_W(VAL_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .cmd      (cmd),
        .wr_pos   (wr_pos),
        .col_idx  (col_idx)
    );

    sort_hot_matrix #(.VAL_W(VAL_W)) u_matrix (
        .clk      (clk),
        .rst      (rst),
        .wipe     (cmd.wipe),
        .write    (cmd.write),
        .wr_pos   (wr_pos),
        .wr_val   (in_data),
        .col_idx  (col_idx),
        .col_bits (col_bits)
    );

    sort_shift_buf #(.VAL_W(VAL_W)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .shift (cmd.write),
        .din   (in_data),
        .elems (elems)
    );

    sort_col_gate #(.VAL_W(VAL_W)) u_gate (
        .col_bits  (col_bits),
        .elems     (elems),
        .sel_value (sel_value),
        .sel_count (sel_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_count <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= cmd.scan && (sel_count != '0);
            done      <= cmd.finish;
            if (cmd.scan) begin
                out_value <= sel_value;
                out_count <= sel_count;
            end
        end
    end
endmodule

// File: rtl/sorter_checker.sv
module sorter_checker #(
    parameter int unsigned VAL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [VAL_W-1:0] out_value,
    input logic [VAL_W:0]   out_count,
    input logic             done
);
    localparam int unsigned N = 1 << VAL_W;

    logic             seen_q;
    logic [VAL_W-1:0] prev_q;
    logic [VAL_W:0]   taken_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            seen_q  <= 1'b0;
            prev_q  <= '0;
            taken_q <= '0;
        end else begin
            if (out_valid) begin
                seen_q <= 1'b1;
                prev_q <= out_value;
            end
            if (in_valid && in_ready) taken_q <= taken_q + 1'b1;
        end
    end

    assert_accept_bound_R2: assert property (@(posedge clk) disable iff (rst)
        taken_q <= (VAL_W+1)'(N));
    assert_descending_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen_q) |-> (out_value < prev_q));
    assert_count_cap_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_count <= (VAL_W+1)'(N)));
    assert_no_empty_beat_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_count != '0));
    assert_ready_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);
    assert_start_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> !in_ready);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);
endmodule

bind onehot_sorter sorter_checker #(.VAL_W(VAL_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_value (out_value),
    .out_count (out_count),
    .done      (done)
);

// File: tb/tb_onehot_sorter.sv
module tb_onehot_sorter;
    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready;
    logic         out_valid;
    logic [W-1:0] out_value;
    logic [W:0]   out_count;
    logic         done;

    onehot_sorter #(.VAL_W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_value(out_value), .out_count(out_count), .done(done)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int batch [N];
    int bv [2*N];
    int bc [2*N];
    int nbeats, acc_n, acc_edge, done_n, done_cyc;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (in_valid && in_ready) begin
            acc_n++;
            acc_edge = cyc + 1;
        end
        if (out_valid && nbeats < 2*N) begin
            bv[nbeats] = int'(out_value);
            bc[nbeats] = int'(out_count);
            nbeats++;
        end
        if (done) begin
            done_n++;
            done_cyc = cyc;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
        summary();
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
        end
    endtask

    task automatic clear_mon();
        nbeats = 0; acc_n = 0; done_n = 0; done_cyc = -1; acc_edge = -1;
    endtask

    task automatic pulse_start(input bit with_valid, input int vdata);
        @(posedge clk); #1;
        start = 1; in_valid = with_valid; in_data = W'(vdata);
        @(posedge clk); #1;
        start = 0; in_valid = 0;
        clear_mon();
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after start", int'(in_ready), 1);
    endtask

    task automatic load_batch(input bit bubbles);
        for (int i = 0; i < N; i++) begin
            if (bubbles) begin
                int gap = int'($urandom % 3);
                in_valid = 0;
                for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
            end
            in_valid = 1; in_data = W'(batch[i]);
            @(posedge clk); #1;
        end
        in_valid = 0;
        @(negedge clk);
        chk(acc_n == N, "R2 accepted count", acc_n, N);
        chk(in_ready == 1'b0, "R2 ready low after N", int'(in_ready), 0);
    endtask

    task automatic finish_read(input bit noise, input string tag);
        int hist [N];
        int k;
        int sum;
        for (int t = 0; t < 3*N && done_n == 0; t++) begin
            @(posedge clk); #1;
            if (noise) begin in_valid = 1; in_data = W'($urandom); end
        end
        in_valid = 0;
        chk(done_n == 1, {"R8 done seen ", tag}, done_n, 1);
        chk(done_cyc == acc_edge + N + 1, {"R5 done timing ", tag}, done_cyc, acc_edge + N + 1);
        @(negedge clk);
        chk(done == 1'b0, {"R8 done one cycle ", tag}, int'(done), 0);
        for (int v = 0; v < N; v++) hist[v] = 0;
        for (int i = 0; i < N; i++) hist[batch[i]]++;
        k = 0; sum = 0;
        for (int v = N - 1; v >= 0; v--) begin
            if (hist[v] != 0) begin
                if (k < nbeats) begin
                    chk(bv[k] == v, {"R3 beat value ", tag}, bv[k], v);
                    chk(bc[k] == hist[v], {"R3 beat count ", tag}, bc[k], hist[v]);
                end
                k++;
            end
        end
        for (int i = 0; i < nbeats; i++) sum += bc[i];
        chk(nbeats == k, {"R4 beat number ", tag}, nbeats, k);
        chk(sum == N, {"R3 count sum ", tag}, sum, N);
    endtask

    initial begin
        void'($urandom(32'd2024));
        clear_mon();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(in_ready == 0, "R1 reset ready", int'(in_ready), 0);
        chk(out_valid == 0, "R1 reset out_valid", int'(out_valid), 0);
        chk(done == 0, "R1 reset done", int'(done), 0);

        // all equal: one beat with count N
        for (int i = 0; i < N; i++) batch[i] = 9;
        pulse_start(0, 0); load_batch(0); finish_read(0, "equal");

        // all distinct, reverse order
        for (int i = 0; i < N; i++) batch[i] = N - 1 - i;
        pulse_start(0, 0); load_batch(0); finish_read(0, "distinct");

        // extremes only
        for (int i = 0; i < N; i++) batch[i] = (i % 2 == 0) ? 0 : N - 1;
        pulse_start(0, 0); load_batch(1); finish_read(1, "extremes");

        // R6: inputs offered while idle do nothing
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 in_valid = 1; in_data = W'(i);
            @(negedge clk);
            chk(in_ready == 0 && out_valid == 0, "R6 idle ignore",
                int'({in_ready, out_valid}), 0);
        end
        in_valid = 0;

        // R7: restart mid-read, start with in_valid carrying a foreign value
        for (int i = 0; i < N; i++) batch[i] = int'($urandom % 5);
        pulse_start(0, 0); load_batch(0);
        repeat (5) @(posedge clk);
        for (int i = 0; i < N; i++) batch[i] = int'($urandom % 8);
        pulse_start(1, N - 1);
        load_batch(1);
        finish_read(1, "R7 restart");

        // random batches with repeats, bubbles and noise during readout (R6)
        for (int b = 0; b < 6; b++) begin
            int range = 2 + int'($urandom % (N - 1));
            for (int i = 0; i < N; i++) batch[i] = int'($urandom % range);
            pulse_start(0, 0); load_batch(b % 2 == 0); finish_read(1, "R6 random");
        end

        summary();
    end
endmodule